// File: doc/BRIEF.md
# Image Sensor Register Read Sequencer

This block fetches one byte from a register inside an image sensor over a two-wire serial bus. It drives the clock and data wires itself, one bus phase per expiry of an internal phase timer. A start pulse launches the read. The block latches the 7-bit sensor address and the 8-bit register index. It sends the address with a write direction bit and then the register index. It closes that half with a full stop condition, not a repeated start. It then starts again and sends the address with a read direction bit, shifts in one data byte, and answers it with a not-acknowledge followed by a stop.

Both bus wires are modelled as open-drain. Each output says "pull this wire low". The released level comes from an external pull-up. The data wire is read back through a separate input so that acknowledges and read bits can be sampled. When the transfer finishes, a one-cycle done pulse marks it, and the captured byte appears on the read-data output. An error flag reports any acknowledge slot in which the sensor failed to pull the data wire low.

Top module: `sensor_reg_reader`

## Requirements
- R1: After reset both bus wires are released (neither pull-low output asserted), and busy, done and the error flag are all low.
- R2: A transfer produces, on the bus, exactly this event order: start, byte {addr,0}, register index byte, stop, start, byte {addr,1}, stop, with the received data byte between the second address and the final stop.
- R3: The data wire changes while the clock wire is high only to form a start (data falling) or a stop (data rising); bytes are sent most significant bit first.
- R4: The read byte is assembled most significant bit first from data samples taken while the clock is high, and is on `rd_data_o` when `done_o` pulses; it holds until the next read's data bits arrive.
- R5: After the data byte the master leaves data released (high) for the ninth clock pulse, a not-acknowledge, never an acknowledge.
- R6: In every acknowledge slot and every read bit the master releases the data wire before raising the clock; with an acknowledging sensor the error flag stays 0.
- R7: A high data sample in any acknowledge slot sets `err_o`. The transfer still runs to its end, with both stops and the same duration.
- R8: `err_o` is sticky: it stays set after done and is cleared only when the next start pulse is accepted.
- R9: Every bus phase lasts PHASE_CLKS clocks and a transfer has 109 phases. `done_o` is a single-cycle pulse exactly 109*PHASE_CLKS cycles after the clock edge that accepts the start.
- R10: `busy_o` is high from the cycle after an accepted start until done. A start pulse while busy is ignored: it changes neither the bus traffic nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, accepted only while idle |
| dev_addr_i | input | 7 | Sensor bus address, latched at launch |
| reg_idx_i | input | 8 | Register index to read, latched at launch |
| rd_data_o | output | 8 | Byte read from the sensor |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| err_o | output | 1 | Sticky missing-acknowledge flag |
| busy_o | output | 1 | Transfer in progress |
| scl_low_o | output | 1 | Pull clock wire low when 1 |
| sda_low_o | output | 1 | Pull data wire low when 1 |
| sda_in_i | input | 1 | Sampled level of the data wire |

## Verification
Bus levels follow the internal phase state one clock later. Done and the cleared error flag are both due on the launch edge's registered outputs. The bench therefore counts falling clock edges from the edge that accepts a start: busy and a cleared error must show at count 0, and done must first appear at count 109*PHASE_CLKS and be gone one cycle later. A behavioural sensor model on the open-drain wires decodes starts, stops and bytes, acknowledges or ignores its address, and serves the data byte. Every protocol check compares its event log and observed master acknowledge against expected values built from the address and index given to the bench.

// File: rtl/srd_pkg.sv
package srd_pkg;

    typedef enum logic [2:0] {
        OP_START,
        OP_STOP,
        OP_WADDR,
        OP_WIDX,
        OP_RADDR,
        OP_GETACK,
        OP_RBYTE,
        OP_NACK
    } srd_op_e;

    localparam int STEPS  = 12;
    localparam int STEP_W = $clog2(STEPS);

    typedef struct packed {
        logic scl;
        logic sda;
        logic smp;
    } lines_t;

    // transaction program; its order is the bus protocol itself
    function automatic srd_op_e step_op(input logic [STEP_W-1:0] s);
        srd_op_e o;
        case (s)
            4'd0:    o = OP_START;
            4'd1:    o = OP_WADDR;
            4'd2:    o = OP_GETACK;
            4'd3:    o = OP_WIDX;
            4'd4:    o = OP_GETACK;
            4'd5:    o = OP_STOP;
            4'd6:    o = OP_START;
            4'd7:    o = OP_RADDR;
            4'd8:    o = OP_GETACK;
            4'd9:    o = OP_RBYTE;
            4'd10:   o = OP_NACK;
            default: o = OP_STOP;
        endcase
        return o;
    endfunction

    function automatic logic [3:0] op_bits(input srd_op_e op);
        return (op inside {OP_WADDR, OP_WIDX, OP_RADDR, OP_RBYTE}) ? 4'd8 : 4'd1;
    endfunction

    function automatic logic [1:0] op_subs(input srd_op_e op);
        return (op inside {OP_START, OP_RBYTE, OP_NACK}) ? 2'd2 : 2'd3;
    endfunction

    // wire levels (1 = released) for one sub-phase
    function automatic lines_t op_lines(input srd_op_e op, input logic [1:0] sub,
                                        input logic txbit);
        lines_t r;
        r = '{scl: 1'b1, sda: 1'b1, smp: 1'b0};
        case (op)
            OP_START:  begin r.scl = (sub == 2'd0); r.sda = 1'b0; end
            OP_STOP:   begin r.scl = (sub != 2'd0); r.sda = (sub == 2'd2); end
            OP_WADDR,
            OP_WIDX,
            OP_RADDR:  begin r.scl = (sub == 2'd1); r.sda = txbit; end
            OP_GETACK: begin r.scl = (sub == 2'd1); r.smp = (sub == 2'd1); end
            OP_RBYTE:  begin r.scl = (sub == 2'd0); r.smp = (sub == 2'd0); end
            OP_NACK:   begin r.scl = (sub == 2'd0); end
            default:   r = '{scl: 1'b1, sda: 1'b1, smp: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/srd_phase_timer.sv
module srd_phase_timer #(
    parameter int PHASE_CLKS = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (PHASE_CLKS > 2) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) cnt_q <= '0;
        else if (tick)            cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R9
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/srd_step_walker.sv
module srd_step_walker
    import srd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_req,
    input  logic        tick,
    output logic        busy,
    output srd_op_e     op,
    output logic [2:0]  bit_idx,
    output logic [1:0]  sub,
    output logic        finish
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    logic [STEP_W-1:0] step_q;
    logic [2:0]        bit_q;
    logic [1:0]        sub_q;
    logic              busy_q;
    logic              last_sub, last_bit, last_step;

    assign op        = step_op(step_q);
    assign last_sub  = (sub_q == op_subs(op) - 2'd1);
    assign last_bit  = ({1'b0, bit_q} == op_bits(op) - 4'd1);
    assign last_step = (step_q == LAST_STEP);
    assign finish    = busy_q && tick && last_sub && last_bit && last_step;

    assign busy    = busy_q;
    assign bit_idx = bit_q;
    assign sub     = sub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            bit_q  <= '0;
            sub_q  <= '0;
        end else if (!busy_q) begin
            if (start_req) begin
                busy_q <= 1'b1;
                step_q <= '0;
                bit_q  <= '0;
                sub_q  <= '0;
            end
        end else if (tick) begin
            if (!last_sub) begin
                sub_q <= sub_q + 1'b1;
            end else begin
                sub_q <= '0;
                if (!last_bit) begin
                    bit_q <= bit_q + 1'b1;
                end else begin
                    bit_q <= '0;
                    if (last_step) busy_q <= 1'b0;
                    else           step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (start_req && busy_q && !tick) |=> (busy_q && $stable(step_q)));

    // R9
    finish_end_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> !busy_q);

endmodule

// File: rtl/sensor_reg_reader.sv
module sensor_reg_reader
    import srd_pkg::*;
#(
    parameter int PHASE_CLKS = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [6:0] dev_addr_i,
    input  logic [7:0] reg_idx_i,
    output logic [7:0] rd_data_o,
    output logic       done_o,
    output logic       err_o,
    output logic       busy_o,
    output logic       scl_low_o,
    output logic       sda_low_o,
    input  logic       sda_in_i
);
    logic       tick, busy, finish, launch;
    srd_op_e    op;
    logic [2:0] bit_idx;
    logic [1:0] sub;
    logic [6:0] addr_q;
    logic [7:0] idx_q, rx_q, txbyte;
    logic       scl_q, sda_q, done_q, err_q;
    lines_t     lv;

    assign launch = start_i && !busy;

    srd_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .run   (busy),
        .tick  (tick)
    );

    srd_step_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_i),
        .tick      (tick),
        .busy      (busy),
        .op        (op),
        .bit_idx   (bit_idx),
        .sub       (sub),
        .finish    (finish)
    );

    always_comb begin
        case (op)
            OP_WADDR: txbyte = {addr_q, 1'b0};
            OP_WIDX:  txbyte = idx_q;
            OP_RADDR: txbyte = {addr_q, 1'b1};
            default:  txbyte = 8'h00;
        endcase
        lv = op_lines(op, sub, txbyte[3'd7 - bit_idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rx_q   <= '0;
            addr_q <= '0;
            idx_q  <= '0;
        end else begin
            done_q <= finish;
            scl_q  <= busy ? lv.scl : 1'b1;
            sda_q  <= busy ? lv.sda : 1'b1;
            if (launch) begin
                addr_q <= dev_addr_i;
                idx_q  <= reg_idx_i;
                err_q  <= 1'b0;
            end
            if (busy && tick && lv.smp) begin
                if (op == OP_GETACK && sda_in_i) err_q <= 1'b1;
                if (op == OP_RBYTE)              rx_q  <= {rx_q[6:0], sda_in_i};
            end
        end
    end

    assign rd_data_o = rx_q;
    assign done_o    = done_q;
    assign err_o     = err_q;
    assign busy_o    = busy;
    assign scl_low_o = ~scl_q;
    assign sda_low_o = ~sda_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $fell(busy_o));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o && !launch) |=> err_o);

    // R6
    rel_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (op inside {OP_GETACK, OP_RBYTE, OP_NACK})) |=> !sda_low_o);

    // R3
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_low_o && $past(!scl_low_o) && (sda_low_o != $past(sda_low_o)))
        |-> $past(op inside {OP_START, OP_STOP}));

endmodule

// File: tb/sensor_reg_reader_test.sv
module sensor_reg_reader_test;
    localparam int P     = 8;
    localparam int NPH   = 109;
    localparam int SADDR = 7'h21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] idx = '0;
    logic [7:0] rd_data;
    logic       done, err, busy, scl_low, sda_low;
    logic       scl_line, sda_line;
    logic       slv_low = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign scl_line = ~scl_low;
    assign sda_line = ~(sda_low | slv_low);

    sensor_reg_reader #(.PHASE_CLKS(P)) uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .dev_addr_i (addr),
        .reg_idx_i  (idx),
        .rd_data_o  (rd_data),
        .done_o     (done),
        .err_o      (err),
        .busy_o     (busy),
        .scl_low_o  (scl_low),
        .sda_low_o  (sda_low),
        .sda_in_i   (sda_line)
    );

    // behavioural sensor on the open-drain wires
    logic [9:0] ev_log [0:15];
    int   ev_n = 0;
    logic [7:0] slv_data = 8'h00;
    int   mode = 0;
    int   bitc = 0;
    int   txc = 0;
    logic [7:0] sh = '0;
    bit   first = 0, isread = 0, mack_seen = 0;
    logic mack_bit = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    task automatic log_ev(input logic [9:0] v);
        if (ev_n < 16) ev_log[ev_n] = v;
        ev_n++;
    endtask

    always @(scl_line, sda_line) begin
        if (scl_line === 1'b1 && prev_scl === 1'b1 && sda_line === 1'b0 && prev_sda === 1'b1) begin
            log_ev(10'h100); mode = 1; bitc = 0; first = 1; sh = '0; slv_low = 1'b0;
        end else if (scl_line === 1'b1 && prev_scl === 1'b1 && sda_line === 1'b1 && prev_sda === 1'b0) begin
            log_ev(10'h200); mode = 0; slv_low = 1'b0;
        end else if (scl_line === 1'b1 && prev_scl === 1'b0) begin
            case (mode)
                1: begin sh = {sh[6:0], sda_line}; bitc++; end
                3: txc++;
                4: begin mack_bit = sda_line; mack_seen = 1; end
                default: ;
            endcase
        end else if (scl_line === 1'b0 && prev_scl === 1'b1) begin
            case (mode)
                1: if (bitc == 8) begin
                       log_ev({2'b00, sh});
                       if (first && sh[7:1] != 7'(SADDR)) mode = 0;
                       else begin slv_low = 1'b1; isread = first && sh[0]; mode = 2; end
                       first = 0;
                   end
                2: begin
                       slv_low = 1'b0;
                       if (isread) begin txc = 0; slv_low = ~slv_data[7]; mode = 3; end
                       else begin bitc = 0; mode = 1; end
                   end
                3: if (txc == 8) begin slv_low = 1'b0; mode = 4; end
                   else slv_low = ~slv_data[7 - txc];
                4: mode = 0;
                default: ;
            endcase
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // launch one transfer; cyc counts falling edges after the accepting edge
    task automatic run_txn(input logic [6:0] a, input logic [7:0] ix, input bit poke,
                           output int cyc, output bit busy0, output bit err0);
        ev_n = 0; mack_seen = 0;
        @(negedge clk); start = 1'b1; addr = a; idx = ix;
        @(negedge clk); start = 1'b0;
        cyc = 0; busy0 = busy; err0 = err;
        while (!done && cyc < 4000) begin
            if (poke && cyc == 200) begin start = 1'b1; addr = 7'h55; idx = 8'h99; end
            @(negedge clk); start = 1'b0; cyc++;
        end
    endtask

    task automatic check_events(input logic [6:0] a, input logic [7:0] ix, input bit acked,
                                input string req);
        logic [9:0] exp [0:6];
        int nexp;
        if (acked) begin
            exp[0] = 10'h100; exp[1] = {2'b00, a, 1'b0}; exp[2] = {2'b00, ix};
            exp[3] = 10'h200; exp[4] = 10'h100; exp[5] = {2'b00, a, 1'b1}; exp[6] = 10'h200;
            nexp = 7;
        end else begin
            exp[0] = 10'h100; exp[1] = {2'b00, a, 1'b0}; exp[2] = 10'h200;
            exp[3] = 10'h100; exp[4] = {2'b00, a, 1'b1}; exp[5] = 10'h200; exp[6] = 10'h000;
            nexp = 6;
        end
        check(ev_n == nexp, {req, " event count"}, ev_n, nexp);
        for (int k = 0; k < nexp && k < ev_n; k++)
            check(ev_log[k] == exp[k], {req, " bus event"}, int'(ev_log[k]), int'(exp[k]));
    endtask

    task automatic t_reset;
        // R1
        check(scl_low == 1'b0 && sda_low == 1'b0, "R1 wires released", {scl_low, sda_low}, 0);
        check(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 status idle", {busy, done, err}, 0);
    endtask

    task automatic t_good_read(input logic [7:0] ix, input logic [7:0] d, input bit poke);
        int cyc; bit b0, e0;
        slv_data = d;
        run_txn(7'(SADDR), ix, poke, cyc, b0, e0);
        // R9 and R10
        check(cyc == NPH * P, "R9 done latency", cyc, NPH * P);
        check(b0 == 1'b1, "R10 busy after start", b0, 1);
        check(e0 == 1'b0, "R8 err cleared at launch", e0, 0);
        // R4
        check(rd_data == d, "R4 read byte", rd_data, d);
        // R6
        check(err == 1'b0, "R6 acks seen, no error", err, 0);
        // R5
        check(mack_seen && mack_bit == 1'b1, "R5 master nack", {mack_seen, mack_bit}, 3);
        // R2, R3 (R10 when poked: the second start must leave traffic untouched)
        check_events(7'(SADDR), ix, 1'b1, poke ? "R10 ignored start" : "R2 R3 order");
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9 single-cycle done", {done, busy}, 0);
    endtask

    task automatic t_missing_ack;
        int cyc; bit b0, e0;
        run_txn(7'h55, 8'h42, 1'b0, cyc, b0, e0);
        // R7
        check(err == 1'b1, "R7 err on missing ack", err, 1);
        check(cyc == NPH * P, "R7 full length after error", cyc, NPH * P);
        check_events(7'h55, 8'h42, 1'b0, "R7 stops still sent");
        // R8
        repeat (20) @(negedge clk);
        check(err == 1'b1, "R8 err sticky while idle", err, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good_read(8'h0A, 8'hA5, 1'b0);
        t_good_read(8'hF1, 8'h3C, 1'b0);
        t_good_read(8'h80, 8'h01, 1'b0);
        t_missing_ack();
        t_good_read(8'h01, 8'h80, 1'b0);
        t_good_read(8'h5E, 8'hC3, 1'b1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule